// File: doc/BRIEF.md
# Serial Port Bit-Rate Generator

This block produces the timing pulses a serial port needs for both free-running (asynchronous) and clocked (synchronous) framing. A reload counter counts system clocks up to a programmable divisor `n` and emits an oversample pulse each time it wraps. A second, small counter divides those pulses by a prescale of 64, 16 or 4, picked from three mode inputs, and emits the bit-rate pulse. The bit rate is therefore the clock frequency divided by `prescale × (n + 1)`.

The divisor is held in two byte registers, written one byte at a time. A narrow mode uses only the low byte, and a wide mode joins both bytes into a 16-bit value. Any write to either byte restarts both counters at once, so a new rate takes effect immediately rather than after the old period runs out. The block also cleans the receive line: it samples the line on each oversample pulse and outputs the majority value of the last three samples.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both divisor bytes are zero, the narrow mode applies, the receive samples are all 1 and `rx_clean` is 1. With all mode inputs low, `os_tick` is high in every cycle, and the first `bit_tick` is high in the 64th cycle after reset is released (cycle index 63).
- R2: `os_tick` is high for one cycle in every `n + 1` clock cycles.
- R3: With `sync_mode`=0, the bit period is `P × (n + 1)` clocks. P is 64 when `wide_mode`=0 and `fast_mode`=0, 16 when exactly one of the two is 1, and 4 when both are 1.
- R4: With `sync_mode`=1, P is 4 whatever the value of `fast_mode`.
- R5: With `wide_mode`=0, `n` is the low byte and the high byte has no effect. With `wide_mode`=1, `n` is {high byte, low byte}.
- R6: A write through `wr_lo` or `wr_hi` clears both counters at the clock edge that takes the write. The first `bit_tick` after the write is then high in the cycle index `P × (n + 1) − 1`, where the cycle after the write edge is index 0.
- R7: `bit_tick` lasts exactly one cycle and is high only while `os_tick` is high.
- R8: `rx_in` is sampled at every clock edge where `os_tick` is high. `rx_clean` is the majority of the last three samples and changes only after such an edge.
- R9: A low level on `rx_in` that is caught by only one sample does not change `rx_clean`.
- R10: With `sync_mode`=0, `wide_mode`=0, `fast_mode`=0 and a low byte of 25, the bit period is 1664 clocks, which is about 9615 baud at 16 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_lo | input | 1 | Write strobe for the low divisor byte |
| wr_hi | input | 1 | Write strobe for the high divisor byte |
| wr_data | input | DW | Write data byte |
| sync_mode | input | 1 | 1 selects synchronous mode |
| wide_mode | input | 1 | 1 selects the 16-bit divisor |
| fast_mode | input | 1 | Selects the smaller asynchronous prescale |
| rx_in | input | 1 | Raw receive line |
| bit_tick | output | 1 | One-cycle pulse at the bit rate |
| os_tick | output | 1 | One-cycle pulse every n+1 clocks |
| rx_clean | output | 1 | Receive line after the majority vote |

## Verification
The main function is exercised with a set of mode and divisor pairs that covers each of the three asynchronous prescales, synchronous mode with `fast_mode` both low and high, a nonzero high byte in narrow and in wide mode, and the smallest divisor of zero. Measuring the steady period separates a wrong prescale from a wrong divisor choice. Measuring the first tick after a write shows whether the counters restart. Changing `rx_in` at steps relative to `os_tick` tells a true majority vote apart from a plain follower or a filter that samples every clock.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic          sync_mode,
  input  logic          wide_mode,
  input  logic          fast_mode,
  input  logic          rx_in,
  output logic          bit_tick,
  output logic          os_tick,
  output logic          rx_clean
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] div_lo, div_hi;
  logic [CW-1:0] cnt, n_eff;
  logic [5:0]    pre, pre_top;
  logic [2:0]    samp;

  assign n_eff   = wide_mode ? {div_hi, div_lo} : {{DW{1'b0}}, div_lo};
  assign pre_top = sync_mode              ? 6'd3  :
                   (wide_mode & fast_mode) ? 6'd3  :
                   (wide_mode | fast_mode) ? 6'd15 : 6'd63;

  assign os_tick  = (cnt >= n_eff);
  assign bit_tick = os_tick && (pre >= pre_top);
  assign rx_clean = (samp[0] & samp[1]) | (samp[1] & samp[2]) | (samp[0] & samp[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo <= '0;
      div_hi <= '0;
    end else begin
      if (wr_lo) div_lo <= wr_data;
      if (wr_hi) div_hi <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (wr_lo || wr_hi) begin
      cnt <= '0;
      pre <= '0;
    end else if (os_tick) begin
      cnt <= '0;
      pre <= (pre >= pre_top) ? 6'd0 : pre + 6'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp <= 3'b111;
    else if (os_tick) samp <= {samp[1:0], rx_in};
  end
endmodule

module uart_baud_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_lo,
  input logic wr_hi,
  input logic bit_tick,
  input logic os_tick,
  input logic rx_clean
);
  AST_BIT_IN_OS:    assert property (@(posedge clk) disable iff (!rst_n) bit_tick |-> os_tick);               // R7
  AST_BIT_ONE_CYC:  assert property (@(posedge clk) disable iff (!rst_n) bit_tick |=> !bit_tick);             // R7
  AST_WR_RESTART:   assert property (@(posedge clk) disable iff (!rst_n) (wr_lo || wr_hi) |=> !bit_tick);     // R6
  AST_CLEAN_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !os_tick |=> $stable(rx_clean));     // R8
endmodule

bind uart_baud_gen uart_baud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
  .bit_tick(bit_tick), .os_tick(os_tick), .rx_clean(rx_clean)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
  logic clk = 0, rst_n = 0;
  logic wr_lo = 0, wr_hi = 0;
  logic [7:0] wr_data = 0;
  logic sync_mode = 0, wide_mode = 0, fast_mode = 0, rx_in = 1;
  logic bit_tick, os_tick, rx_clean;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  uart_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .sync_mode(sync_mode), .wide_mode(wide_mode), .fast_mode(fast_mode),
    .rx_in(rx_in), .bit_tick(bit_tick), .os_tick(os_tick), .rx_clean(rx_clean)
  );

  // {sync, wide, fast, hi, lo, expected bit period}
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {3'b000, 8'd0, 8'd25, 18'd1664},  // R10 R3
    {3'b001, 8'd0, 8'd3,  18'd64},    // R3
    {3'b010, 8'd1, 8'd2,  18'd4144},  // R3 R5
    {3'b011, 8'd0, 8'd5,  18'd24},    // R3
    {3'b100, 8'd0, 8'd9,  18'd40},    // R4
    {3'b101, 8'd0, 8'd9,  18'd40},    // R4
    {3'b000, 8'd7, 8'd2,  18'd192},   // R5
    {3'b111, 8'd0, 8'd0,  18'd4},     // R4
    {3'b010, 8'd0, 8'd0,  18'd16}     // R3
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    @(negedge clk);
    wr_hi = hi; wr_lo = !hi; wr_data = d;
    @(negedge clk);
    wr_hi = 0; wr_lo = 0;
  endtask

  function automatic int cycles_to_bit();
    return 0;
  endfunction

  task automatic to_bit(output int k);
    k = 0;
    while (!bit_tick) begin @(negedge clk); k++; end
  endtask

  task automatic to_os(output int k);
    k = 0;
    while (!os_tick) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, index 0 is this negedge
    check("R1 os_tick", os_tick, 1);
    check("R1 rx_clean", rx_clean, 1);
    check("R1 bit_tick", bit_tick, 0);
    to_bit(k);
    check("R1 first bit index", k, 63);

    foreach (VEC[i]) begin
      logic [36:0] v;
      int n, per;
      v = VEC[i];
      sync_mode = v[36]; wide_mode = v[35]; fast_mode = v[34];
      n   = v[35] ? int'(v[33:18]) : int'(v[25:18]);
      per = int'(v[17:0]);
      wr(1, v[33:26]);
      wr(0, v[25:18]);
      to_bit(k);
      check($sformatf("R6 first tick vec%0d", i), k, per - 1);
      @(negedge clk);
      to_bit(k);
      check($sformatf("R3/R4/R5 period vec%0d", i), k + 1, per);
      if (n > 0) begin
        @(negedge clk);
        to_os(k);
        @(negedge clk);
        to_os(k);
        check($sformatf("R2 os period vec%0d", i), k + 1, n + 1);
      end
    end

    // R6: mid-period write restarts at once
    sync_mode = 0; wide_mode = 0; fast_mode = 0;
    wr(0, 8'd25);
    repeat (1000) @(negedge clk);
    wr(0, 8'd25);
    to_bit(k);
    check("R6 restart mid-period", k, 1663);

    // R8: majority follows after two samples
    wr(0, 8'd3);
    @(negedge clk);
    rx_in = 0;
    to_os(k);
    @(negedge clk);
    check("R8 after one sample", rx_clean, 1);
    to_os(k);
    @(negedge clk);
    check("R8 after two samples", rx_clean, 0);
    rx_in = 1;
    repeat (3) begin to_os(k); @(negedge clk); end
    check("R8 back high", rx_clean, 1);

    // R9: glitch caught by one sample only
    to_os(k);
    rx_in = 0;
    @(negedge clk);
    rx_in = 1;
    check("R9 glitch after sample", rx_clean, 1);
    repeat (3) begin to_os(k); @(negedge clk); end
    check("R9 glitch rejected", rx_clean, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule